// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Unit

This unit resolves data hazards for a five-stage in-order pipeline whose stages run fetch, decode, execute, memory, writeback. Each cycle it takes the instruction held in the fetch/decode register: its 5-bit opcode and three 5-bit register fields (rd, rs, rt). It decodes which registers that instruction reads and writes, and passes the result through its own descriptor registers that shadow the decode/execute, execute/memory and memory/writeback registers. From these descriptors it drives the select lines of the two execute-stage operand multiplexers and of the memory-stage store-data multiplexer. It also drives a stall. While the stall is high, the surrounding pipeline holds the PC and the fetch/decode register, and the unit loads an empty descriptor (a bubble) into its decode/execute slot.

Operand A is always the rs register. Operand B is the rt register for a register-type ALU operation. For a compare-and-branch and for a store, operand B is the rd register, so the stored value can be forwarded in execute like any other operand. The register file is taken to be written early in the cycle, so an instruction three places behind a producer needs no bypass. The register file, ALU, memories and branch resolution live outside the unit.

Top module: `bypass_stall_unit`

## Requirements
- R1: While reset is asserted, and after it is released until an instruction has entered, stall is 0 and opa_sel, opb_sel and st_sel are all 0.
- R2: Select encoding is 0 = register file, 1 = memory-stage result, 2 = writeback-stage result. opa_sel is 1 when the instruction in execute reads rs and the memory-stage instruction writes that same register and is not a load.
- R3: Operand B uses rt for opcode 00000 (ALU op: reads rs and rt, writes rd). It uses rd for opcodes 00010 and 00110 (compare-and-branch: read rd and rs) and for opcode 00111 (store: reads rs as base and rd as data). Opcodes 00101 (add immediate) and 01000 (load) read only rs, so opb_sel stays 0 for them.
- R4: An operand select is 2 when the writeback-stage instruction writes the source register (loads included) and the memory stage does not qualify for that operand.
- R5: When both the memory and the writeback stage write the source register, the memory stage wins (select 1).
- R6: Register 0 never causes a bypass select other than 0, never sets st_sel, and never causes a stall.
- R7: A load in the memory stage is never a bypass source. A store right after a load whose data register (rd) matches the load destination does not stall.
- R8: st_sel is 1 when the memory-stage instruction is a store whose rd matches the writeback-stage destination of a register-writing instruction.
- R9: stall is 1 in the cycle when a load is in execute and the instruction in decode reads the load destination through rs, through rt (ALU op), or through rd (compare-and-branch).
- R10: After a stall cycle the execute slot holds a bubble: both operand selects are 0 that cycle. The stalled instruction then proceeds and takes the load value through select 2.
- R11: Jump-type opcodes 00001, 10111 and 11000, and all unlisted opcodes, have no sources and no destination and never stall.
- R12: Only opcodes 00000, 00101 and 01000 write a register. Branches, stores and jumps are never bypass sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| fd_opcode | input | 5 | Opcode in the fetch/decode register |
| fd_rd | input | 5 | rd field in the fetch/decode register |
| fd_rs | input | 5 | rs field in the fetch/decode register |
| fd_rt | input | 5 | rt field in the fetch/decode register |
| stall | output | 1 | Hold PC and fetch/decode register; bubble into execute |
| opa_sel | output | 2 | Execute operand A source (0 reg, 1 memory, 2 writeback) |
| opb_sel | output | 2 | Execute operand B source (0 reg, 1 memory, 2 writeback) |
| st_sel | output | 1 | Memory-stage store data from writeback result |

## Verification
The hardest case to reach from the ports is a load followed by a store of the loaded register. The store must not stall. It must not take the unfinished load in the memory stage, and one cycle later it must pick up the load value through st_sel. The bench reaches this case, together with the stall-and-bubble sequence, through directed back-to-back instruction pairs. A long pseudo-random instruction stream over registers 0 to 3 then crowds together every producer/consumer distance and class combination. Expected selects and stall come from an arithmetic model of the requirements that advances each cycle and honours the stall itself.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int OPC_W = 5;
  localparam int REG_W = 5;

  localparam logic [OPC_W-1:0] OP_ALU    = 5'b00000;
  localparam logic [OPC_W-1:0] OP_JMP    = 5'b00001;
  localparam logic [OPC_W-1:0] OP_BNE    = 5'b00010;
  localparam logic [OPC_W-1:0] OP_ADDI   = 5'b00101;
  localparam logic [OPC_W-1:0] OP_BLT    = 5'b00110;
  localparam logic [OPC_W-1:0] OP_STORE  = 5'b00111;
  localparam logic [OPC_W-1:0] OP_LOAD   = 5'b01000;
  localparam logic [OPC_W-1:0] OP_TMRSET = 5'b10111;
  localparam logic [OPC_W-1:0] OP_TMRBR  = 5'b11000;

  localparam logic [1:0] SEL_REG = 2'd0;
  localparam logic [1:0] SEL_MEM = 2'd1;
  localparam logic [1:0] SEL_WB  = 2'd2;

  typedef struct packed {
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src_a;
    logic [REG_W-1:0] src_b;
    logic             use_a;
    logic             use_b;
    logic             wr;
    logic             ld;
    logic             st;
  } hz_desc_t;

  localparam hz_desc_t DESC_NOP = '0;
endpackage

// File: rtl/hz_decode.sv
module hz_decode
  import hz_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [REG_W-1:0] rd,
  input  logic [REG_W-1:0] rs,
  input  logic [REG_W-1:0] rt,
  output hz_desc_t         desc
);
  always_comb begin
    desc = DESC_NOP;
    case (opcode)
      OP_ALU: begin
        desc.dst   = rd;
        desc.src_a = rs;
        desc.src_b = rt;
        desc.use_a = 1'b1;
        desc.use_b = 1'b1;
        desc.wr    = 1'b1;
      end
      OP_ADDI: begin
        desc.dst   = rd;
        desc.src_a = rs;
        desc.use_a = 1'b1;
        desc.wr    = 1'b1;
      end
      OP_LOAD: begin
        desc.dst   = rd;
        desc.src_a = rs;
        desc.use_a = 1'b1;
        desc.wr    = 1'b1;
        desc.ld    = 1'b1;
      end
      OP_STORE: begin
        desc.src_a = rs;
        desc.src_b = rd;
        desc.use_a = 1'b1;
        desc.use_b = 1'b1;
        desc.st    = 1'b1;
      end
      OP_BNE, OP_BLT: begin
        desc.src_a = rs;
        desc.src_b = rd;
        desc.use_a = 1'b1;
        desc.use_b = 1'b1;
      end
      default: desc = DESC_NOP;
    endcase
  end
endmodule

// File: rtl/hz_track.sv
module hz_track
  import hz_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     adv_en,
  input  logic     stall,
  input  hz_desc_t dec,
  output hz_desc_t dx,
  output hz_desc_t xm,
  output hz_desc_t mw
);
  hz_desc_t dx_nxt, xm_nxt, mw_nxt;

  always_comb begin
    dx_nxt = dx;
    xm_nxt = xm;
    mw_nxt = mw;
    if (adv_en) begin
      dx_nxt = stall ? DESC_NOP : dec;
      xm_nxt = dx;
      mw_nxt = xm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dx <= DESC_NOP;
      xm <= DESC_NOP;
      mw <= DESC_NOP;
    end else begin
      dx <= dx_nxt;
      xm <= xm_nxt;
      mw <= mw_nxt;
    end
  end

  assert_dst_only_writers_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!mw.wr) |-> (mw.dst == '0));
endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int NUM_OPS = 2
)(
  input  logic                          clk,
  input  logic                          rst_n,
  input  hz_desc_t                      xm,
  input  hz_desc_t                      mw,
  input  logic [NUM_OPS-1:0]            use_op,
  input  logic [NUM_OPS-1:0][REG_W-1:0] src_op,
  output logic [NUM_OPS-1:0][1:0]       sel_op
);
  logic mem_ok;
  logic wb_ok;

  always_comb begin
    mem_ok = xm.wr && !xm.ld && (xm.dst != '0);
    wb_ok  = mw.wr && (mw.dst != '0);
  end

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    logic hit_mem, hit_wb;
    always_comb begin
      hit_mem = use_op[i] && mem_ok && (xm.dst == src_op[i]);
      hit_wb  = use_op[i] && wb_ok  && (mw.dst == src_op[i]);
      if (hit_mem)     sel_op[i] = SEL_MEM;
      else if (hit_wb) sel_op[i] = SEL_WB;
      else             sel_op[i] = SEL_REG;
    end

    assert_zero_never_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_op[i] != SEL_REG) |-> (src_op[i] != '0));
    assert_no_load_mem_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_op[i] == SEL_MEM) |-> !xm.ld);
    assert_sel_encoding_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_op[i] != 2'd3);
  end
endmodule

// File: rtl/hz_load_stall.sv
module hz_load_stall
  import hz_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  hz_desc_t         dec,
  input  hz_desc_t         dx,
  output logic             stall
);
  logic hit_a, hit_b, ld_live;

  always_comb begin
    ld_live = dx.ld && dx.wr && (dx.dst != '0);
    hit_a   = dec.use_a && (dec.src_a == dx.dst);
    hit_b   = dec.use_b && !dec.st && (dec.src_b == dx.dst);
    stall   = ld_live && (hit_a || hit_b);
  end

  assert_jump_no_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((opcode == OP_JMP) || (opcode == OP_TMRSET) || (opcode == OP_TMRBR)) |-> !stall);
  assert_store_data_no_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.st && !(dec.use_a && dec.src_a == dx.dst)) |-> !stall);
endmodule

// File: rtl/bypass_stall_unit.sv
module bypass_stall_unit
  import hz_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] fd_opcode,
  input  logic [REG_W-1:0] fd_rd,
  input  logic [REG_W-1:0] fd_rs,
  input  logic [REG_W-1:0] fd_rt,
  output logic             stall,
  output logic [1:0]       opa_sel,
  output logic [1:0]       opb_sel,
  output logic             st_sel
);
  localparam int NUM_OPS = 2;

  logic rst_q1, rst_q2;
  hz_desc_t dec, dx, xm, mw;
  logic [NUM_OPS-1:0]            use_op;
  logic [NUM_OPS-1:0][REG_W-1:0] src_op;
  logic [NUM_OPS-1:0][1:0]       sel_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  hz_decode u_dec (
    .opcode (fd_opcode),
    .rd     (fd_rd),
    .rs     (fd_rs),
    .rt     (fd_rt),
    .desc   (dec)
  );

  hz_load_stall u_stall (
    .clk    (clk),
    .rst_n  (rst_q2),
    .opcode (fd_opcode),
    .dec    (dec),
    .dx     (dx),
    .stall  (stall)
  );

  hz_track u_track (
    .clk    (clk),
    .rst_n  (rst_q2),
    .adv_en (1'b1),
    .stall  (stall),
    .dec    (dec),
    .dx     (dx),
    .xm     (xm),
    .mw     (mw)
  );

  always_comb begin
    use_op[0] = dx.use_a;
    src_op[0] = dx.src_a;
    use_op[1] = dx.use_b;
    src_op[1] = dx.src_b;
  end

  hz_fwd_sel #(.NUM_OPS(NUM_OPS)) u_fwd (
    .clk    (clk),
    .rst_n  (rst_q2),
    .xm     (xm),
    .mw     (mw),
    .use_op (use_op),
    .src_op (src_op),
    .sel_op (sel_op)
  );

  always_comb begin
    opa_sel = sel_op[0];
    opb_sel = sel_op[1];
    st_sel  = xm.st && (xm.src_b != '0) && mw.wr && (mw.dst == xm.src_b);
  end

  assert_store_fwd_origin_R8: assert property (@(posedge clk) disable iff (!rst_q2)
    st_sel |-> $past(dx.st));
  assert_single_stall_R9: assert property (@(posedge clk) disable iff (!rst_q2)
    stall |=> !stall);
  assert_bubble_no_fwd_R10: assert property (@(posedge clk) disable iff (!rst_q2)
    stall |=> (opa_sel == SEL_REG) && (opb_sel == SEL_REG));
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_q2 |-> (!stall && !st_sel));
endmodule

// File: tb/bypass_stall_unit_test.sv
`timescale 1ns/1ps
module bypass_stall_unit_test;
  typedef struct packed {
    logic [4:0] dst, a, b;
    logic ua, ub, wr, ld, st;
  } bdesc_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] fd_opcode, fd_rd, fd_rs, fd_rt;
  logic       stall;
  logic [1:0] opa_sel, opb_sel;
  logic       st_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bdesc_t m_dx, m_xm, m_mw;
  logic [31:0] lcg = 32'h1234_5678;

  always #2 clk = ~clk;

  bypass_stall_unit uut (
    .clk(clk), .rst_n(rst_n), .fd_opcode(fd_opcode), .fd_rd(fd_rd),
    .fd_rs(fd_rs), .fd_rt(fd_rt), .stall(stall), .opa_sel(opa_sel),
    .opb_sel(opb_sel), .st_sel(st_sel)
  );

  function automatic bdesc_t bdec(logic [4:0] op, logic [4:0] rd, logic [4:0] rs, logic [4:0] rt);
    bdesc_t d = '0;
    if (op == 5'd0)      begin d.dst = rd; d.a = rs; d.b = rt; d.ua = 1; d.ub = 1; d.wr = 1; end
    else if (op == 5'd5) begin d.dst = rd; d.a = rs; d.ua = 1; d.wr = 1; end
    else if (op == 5'd8) begin d.dst = rd; d.a = rs; d.ua = 1; d.wr = 1; d.ld = 1; end
    else if (op == 5'd7) begin d.a = rs; d.b = rd; d.ua = 1; d.ub = 1; d.st = 1; end
    else if (op == 5'd2 || op == 5'd6) begin d.a = rs; d.b = rd; d.ua = 1; d.ub = 1; end
    return d;
  endfunction

  function automatic logic [1:0] esel(logic u, logic [4:0] r);
    if (!u || r == 0) return 2'd0;
    if (m_xm.wr && !m_xm.ld && m_xm.dst == r) return 2'd1;
    if (m_mw.wr && m_mw.dst == r) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic estall(bdesc_t d);
    if (!(m_dx.ld && m_dx.dst != 0)) return 1'b0;
    return (d.ua && d.a == m_dx.dst) || (d.ub && !d.st && d.b == m_dx.dst);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic issue(logic [4:0] op, logic [4:0] rd, logic [4:0] rs, logic [4:0] rt, string tag);
    bdesc_t d;
    logic es;
    d = bdec(op, rd, rs, rt);
    do begin
      @(negedge clk);
      fd_opcode = op; fd_rd = rd; fd_rs = rs; fd_rt = rt;
      #1;
      es = estall(d);
      check(tag, "stall", int'(stall), int'(es));
      check(tag, "opa_sel", int'(opa_sel), int'(esel(m_dx.ua, m_dx.a)));
      check(tag, "opb_sel", int'(opb_sel), int'(esel(m_dx.ub, m_dx.b)));
      check(tag, "st_sel", int'(st_sel),
            int'(m_xm.st && m_xm.b != 0 && m_mw.wr && m_mw.dst == m_xm.b));
      m_mw = m_xm;
      m_xm = m_dx;
      m_dx = es ? bdesc_t'('0) : d;
    end while (es);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    m_dx = '0; m_xm = '0; m_mw = '0;
    rst_n = 1'b0;
    fd_opcode = 5'b00000; fd_rd = 5'd1; fd_rs = 5'd1; fd_rt = 5'd1;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state with a register-writing instruction presented
    check("R1", "stall", int'(stall), 0);
    check("R1", "opa_sel", int'(opa_sel), 0);
    check("R1", "opb_sel", int'(opb_sel), 0);
    check("R1", "st_sel", int'(st_sel), 0);
    fd_opcode = 5'b11111; fd_rd = 0; fd_rs = 0; fd_rt = 0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R1", "opa_sel", int'(opa_sel), 0);
    check("R1", "stall", int'(stall), 0);

    // R5: both later stages write r1
    issue(5'd5, 5'd1, 5'd0, 5'd0, "R5");
    issue(5'd5, 5'd1, 5'd0, 5'd0, "R5");
    issue(5'd0, 5'd2, 5'd1, 5'd1, "R5");
    issue(5'd1, 5'd0, 5'd0, 5'd0, "R5");
    #0 check("R5", "opa_sel direct", int'(opa_sel), 1);
    // R4: writeback-only match
    issue(5'd5, 5'd2, 5'd0, 5'd0, "R4");
    issue(5'd1, 5'd0, 5'd0, 5'd0, "R4");
    issue(5'd0, 5'd3, 5'd2, 5'd0, "R4");
    issue(5'd1, 5'd0, 5'd0, 5'd0, "R4");
    check("R4", "opa_sel direct", int'(opa_sel), 2);
    // R2: memory-stage match on rs
    issue(5'd5, 5'd9, 5'd0, 5'd0, "R2");
    issue(5'd5, 5'd10, 5'd9, 5'd0, "R2");
    issue(5'd1, 5'd0, 5'd0, 5'd0, "R2");
    check("R2", "opa_sel direct", int'(opa_sel), 1);
    // R6: register 0 producers and consumers
    issue(5'd5, 5'd0, 5'd0, 5'd0, "R6");
    issue(5'd8, 5'd0, 5'd0, 5'd0, "R6");
    issue(5'd0, 5'd4, 5'd0, 5'd0, "R6");
    issue(5'd1, 5'd0, 5'd0, 5'd0, "R6");
    check("R6", "opa_sel direct", int'(opa_sel), 0);
    // R9 and R10: load-use stall, bubble, then writeback bypass
    issue(5'd8, 5'd5, 5'd0, 5'd0, "R9");
    issue(5'd0, 5'd6, 5'd5, 5'd5, "R10");
    issue(5'd1, 5'd0, 5'd0, 5'd0, "R10");
    check("R10", "opa_sel after bubble", int'(opa_sel), 2);
    issue(5'd8, 5'd11, 5'd0, 5'd0, "R9");
    issue(5'd2, 5'd11, 5'd0, 5'd0, "R9");
    // R7 and R8: load then store of the loaded register
    issue(5'd8, 5'd7, 5'd0, 5'd0, "R7");
    issue(5'd7, 5'd7, 5'd0, 5'd0, "R7");
    issue(5'd1, 5'd0, 5'd0, 5'd0, "R7");
    check("R7", "opb_sel store data", int'(opb_sel), 0);
    issue(5'd1, 5'd0, 5'd0, 5'd0, "R8");
    // R3: branch rd as operand B, add-immediate ignores rt
    issue(5'd5, 5'd8, 5'd0, 5'd0, "R3");
    issue(5'd2, 5'd8, 5'd0, 5'd0, "R3");
    issue(5'd5, 5'd12, 5'd0, 5'd8, "R3");
    issue(5'd1, 5'd0, 5'd0, 5'd0, "R3");
    check("R3", "opb_sel addi", int'(opb_sel), 0);
    // R11: jump-type after a load with matching fields
    issue(5'd8, 5'd1, 5'd0, 5'd0, "R11");
    issue(5'd1, 5'd1, 5'd1, 5'd1, "R11");
    issue(5'd8, 5'd1, 5'd0, 5'd0, "R11");
    issue(5'd23, 5'd1, 5'd1, 5'd1, "R11");
    issue(5'd8, 5'd1, 5'd0, 5'd0, "R11");
    issue(5'd24, 5'd1, 5'd1, 5'd1, "R11");
    // R12: branch and store never produce
    issue(5'd2, 5'd3, 5'd3, 5'd0, "R12");
    issue(5'd7, 5'd3, 5'd3, 5'd0, "R12");
    issue(5'd0, 5'd4, 5'd3, 5'd3, "R12");
    issue(5'd1, 5'd0, 5'd0, 5'd0, "R12");
    check("R12", "opa_sel", int'(opa_sel), 0);

    // sweep: dense pseudo-random stream over r0..r3
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] op;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      case (lcg[31:28] % 10)
        0: op = 5'd0;  1: op = 5'd5;  2: op = 5'd8;  3: op = 5'd7;
        4: op = 5'd2;  5: op = 5'd6;  6: op = 5'd1;  7: op = 5'd23;
        8: op = 5'd24; default: op = 5'd31;
      endcase
      issue(op, {3'b0, lcg[21:20]}, {3'b0, lcg[17:16]}, {3'b0, lcg[13:12]}, "R2 sweep");
    end
    finish_run();
  end
endmodule